// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch is taken. It receives a 4-bit condition selector and five processor status flags:

- carry (C)
- overflow (V)
- zero (Z)
- negative (N)
- a spare flag (P)

It produces one bit that is high when the selected condition holds.

Fourteen of the sixteen selectors form seven complementary pairs. Each pair tests a single flag or a signed or unsigned magnitude relation. Selector 14 is unconditionally true. Selector 15 is not "never": it returns the P flag.

A parameter picks the timing variant. In the default variant the decision is purely combinational and follows the inputs in the same cycle. In the other variant one register is placed after the decision, which adds exactly one cycle of latency. In that variant the output is held low while reset is asserted.

Top module: `brcond_eval`

## Requirements
- R1: Selector 0 yields NOT C and selector 1 yields C.
- R2: Selector 2 yields NOT Z and selector 3 yields Z.
- R3: Selector 4 yields NOT V and selector 5 yields V.
- R4: Selector 6 yields NOT N and selector 7 yields N.
- R5: Selector 8 (unsigned lower-or-same) yields C OR Z, and selector 9 (unsigned higher) yields its inverse.
- R6: Selector 10 (signed greater-or-equal) yields V XNOR N, and selector 11 (signed less) yields V XOR N.
- R7: Selector 12 (signed greater) yields NOT((V XOR N) OR Z), and selector 13 (signed less-or-equal) yields (V XOR N) OR Z.
- R8: Selector 14 yields 1 for every flag combination.
- R9: Selector 15 yields the P flag. P has no effect on the result of any other selector.
- R10: With OUT_REG = 0, `cond_true` reflects the current inputs within the same cycle.
- R11: With OUT_REG = 1, `cond_true` is low while `rst_n` is low. After reset it equals the decision for the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the registered variant and by checks) |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_code | input | 4 | Condition selector, 0 to 15 |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_p | input | 1 | Spare flag, read only by selector 15 |
| cond_true | output | 1 | High when the selected condition holds |

## Verification
In the registered variant, two results coexist in every cycle. The register still presents the decision for the previous selector and flags, while the combinational path already evaluates the new ones. The bench runs one instance of each variant side by side over all 16 selectors and all 32 flag patterns, changing the inputs at every falling edge. At that moment the registered output is judged against the expected result of the previous vector, and the combinational output is judged against the current vector shortly afterwards. A stale register or a leak of new inputs into the registered path therefore shows up as a mismatch in one of the two comparisons.

// File: rtl/brcond_pkg.sv
package brcond_pkg;
   localparam int CODE_W = 4;
   localparam int NPAIR  = 7;
   localparam int NCODE  = 2 ** CODE_W;

   // Selector encoding; the numeric order is behaviour.
   typedef enum logic [CODE_W-1:0] {
      CND_CARRY_CLR = 4'd0,
      CND_CARRY_SET = 4'd1,
      CND_ZERO_CLR  = 4'd2,
      CND_ZERO_SET  = 4'd3,
      CND_OVF_CLR   = 4'd4,
      CND_OVF_SET   = 4'd5,
      CND_POS       = 4'd6,
      CND_NEG       = 4'd7,
      CND_ULE       = 4'd8,
      CND_UGT       = 4'd9,
      CND_SGE       = 4'd10,
      CND_SLT       = 4'd11,
      CND_SGT       = 4'd12,
      CND_SLE       = 4'd13,
      CND_ALWAYS    = 4'd14,
      CND_PFLAG     = 4'd15
   } cond_e;

   typedef struct packed {
      logic c;
      logic v;
      logic z;
      logic n;
      logic p;
   } flags_t;

   // Pair k covers codes 2k and 2k+1. A set bit means the odd code
   // is the inverse of the base term, not the term itself.
   localparam logic [NPAIR-1:0] PAIR_INV = 7'b0010000;
endpackage

// File: rtl/brcond_terms.sv
module brcond_terms
   import brcond_pkg::*;
#(
   parameter int PAIRS = NPAIR
) (
   input  flags_t           f,
   output logic [PAIRS-1:0] base
);
   if (PAIRS != 7) begin : g_bad_pairs
      $error("brcond_terms: PAIRS must be 7");
   end

   logic sdiff;

   always_comb begin
      sdiff   = f.v ^ f.n;
      base    = '0;
      base[0] = f.c;
      base[1] = f.z;
      base[2] = f.v;
      base[3] = f.n;
      base[4] = f.c | f.z;
      base[5] = sdiff;
      base[6] = sdiff | f.z;
   end
endmodule

// File: rtl/brcond_select.sv
module brcond_select
   import brcond_pkg::*;
#(
   parameter int PAIRS = NPAIR,
   parameter int SEL_W = CODE_W
) (
   input  flags_t           f,
   input  logic [PAIRS-1:0] base,
   input  logic [SEL_W-1:0] code,
   output logic             hit
);
   localparam int NV = 2 ** SEL_W;

   if (NV != 2 * PAIRS + 2) begin : g_bad_shape
      $error("brcond_select: selector width does not match pair count");
   end

   logic [NV-1:0] vec;

   for (genvar k = 0; k < PAIRS; k++) begin : g_pair
      assign vec[2*k+1] = base[k] ^ PAIR_INV[k];
      assign vec[2*k]   = ~vec[2*k+1];
   end
   assign vec[NV-2] = 1'b1;
   assign vec[NV-1] = f.p;

   assign hit = vec[code];

   always_comb begin
      if (cond_e'(code) == CND_ALWAYS)
         a_r8_always_true : assert (hit == 1'b1);
      if (cond_e'(code) == CND_PFLAG)
         a_r9_spare_flag : assert (hit == f.p);
      if (cond_e'(code) == CND_CARRY_SET)
         a_r1_carry : assert (hit == f.c);
      if (cond_e'(code) == CND_ULE)
         a_r5_lower_same : assert (hit == (f.c | f.z));
      if (cond_e'(code) == CND_SGT)
         a_r7_signed_gt : assert (hit == !((f.v ^ f.n) | f.z));
   end
endmodule

// File: rtl/brcond_stage.sv
module brcond_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
   end

   a_r11_one_cycle : assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (q == $past(d)));
endmodule

// File: rtl/brcond_eval.sv
module brcond_eval
   import brcond_pkg::*;
#(
   parameter int OUT_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] cond_code,
   input  logic              flag_c,
   input  logic              flag_v,
   input  logic              flag_z,
   input  logic              flag_n,
   input  logic              flag_p,
   output logic              cond_true
);
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_outreg
      $error("brcond_eval: OUT_REG must be 0 or 1");
   end

   flags_t           fl;
   logic [NPAIR-1:0] base;
   logic             hit;

   assign fl = '{c: flag_c, v: flag_v, z: flag_z, n: flag_n, p: flag_p};

   brcond_terms #(.PAIRS(NPAIR)) u_terms (
      .f    (fl),
      .base (base)
   );

   brcond_select #(.PAIRS(NPAIR), .SEL_W(CODE_W)) u_sel (
      .f    (fl),
      .base (base),
      .code (cond_code),
      .hit  (hit)
   );

   if (OUT_REG == 1) begin : g_reg
      brcond_stage u_stage (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (hit),
         .q     (cond_true)
      );

      a_r8_always_late : assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(cond_code) == CND_ALWAYS) |-> cond_true);
   end else begin : g_comb
      assign cond_true = hit;

      a_r10_zero_now : assert property (@(posedge clk) disable iff (!rst_n)
         (cond_code == CND_ZERO_SET) |-> (cond_true == flag_z));
   end
endmodule

// File: tb/brcond_eval_test.sv
module brcond_eval_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] code = 4'd0;
   logic       c = 0, v = 0, z = 0, n = 0, p = 0;
   logic       out_reg, out_comb;
   int         n_chk = 0, n_bad = 0;
   bit         done = 0;

   always #2 clk = ~clk;

   brcond_eval #(.OUT_REG(1)) uut (
      .clk(clk), .rst_n(rst_n), .cond_code(code),
      .flag_c(c), .flag_v(v), .flag_z(z), .flag_n(n), .flag_p(p),
      .cond_true(out_reg)
   );

   brcond_eval #(.OUT_REG(0)) uut_comb (
      .clk(clk), .rst_n(rst_n), .cond_code(code),
      .flag_c(c), .flag_v(v), .flag_z(z), .flag_n(n), .flag_p(p),
      .cond_true(out_comb)
   );

   function automatic logic expect_of(input logic [3:0] k, input logic [4:0] f);
      logic fc, fv, fz, fn, fp;
      fc = f[0]; fv = f[1]; fz = f[2]; fn = f[3]; fp = f[4];
      case (k)
         4'd0:  return !fc;
         4'd1:  return fc;
         4'd2:  return !fz;
         4'd3:  return fz;
         4'd4:  return !fv;
         4'd5:  return fv;
         4'd6:  return !fn;
         4'd7:  return fn;
         4'd8:  return fc || fz;
         4'd9:  return !(fc || fz);
         4'd10: return fv == fn;
         4'd11: return fv != fn;
         4'd12: return (fv == fn) && !fz;
         4'd13: return (fv != fn) || fz;
         4'd14: return 1'b1;
         default: return fp;
      endcase
   endfunction

   function automatic string req_of(input logic [3:0] k);
      case (k)
         4'd0, 4'd1:   return "R1";
         4'd2, 4'd3:   return "R2";
         4'd4, 4'd5:   return "R3";
         4'd6, 4'd7:   return "R4";
         4'd8, 4'd9:   return "R5";
         4'd10, 4'd11: return "R6";
         4'd12, 4'd13: return "R7";
         4'd14:        return "R8";
         default:      return "R9";
      endcase
   endfunction

   task automatic check(input string req, input logic act, input logic exp,
                        input logic [3:0] k, input logic [4:0] f);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s code=%0d flags(pnzvc)=%b actual=%b expected=%b",
                  req, k, f, act, exp);
      end
   endtask

   initial begin
      logic       prev_exp;
      logic [3:0] prev_k;
      logic [4:0] prev_f;
      logic       have_prev;
      have_prev = 0;
      prev_exp  = 0;
      prev_k    = 0;
      prev_f    = 0;
      // R11: registered output held low during reset
      code = 4'd14;
      repeat (3) @(negedge clk);
      check("R11", out_reg, 1'b0, code, 5'b0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 16; k++) begin
         for (int fi = 0; fi < 32; fi++) begin
            @(negedge clk);
            // R11: value captured at the last rising edge is the previous vector
            if (have_prev)
               check($sformatf("R11/%s", req_of(prev_k)), out_reg, prev_exp, prev_k, prev_f);
            code = 4'(k);
            {p, n, z, v, c} = 5'(fi);
            #1;
            // R10 with R1..R9 per selector: same-cycle combinational result
            check($sformatf("R10/%s", req_of(4'(k))), out_comb,
                  expect_of(4'(k), 5'(fi)), 4'(k), 5'(fi));
            prev_exp  = expect_of(4'(k), 5'(fi));
            prev_k    = 4'(k);
            prev_f    = 5'(fi);
            have_prev = 1;
         end
      end
      @(negedge clk);
      check("R11", out_reg, prev_exp, prev_k, prev_f);
      done = 1;
   end

   initial begin
      for (int t = 0; t < 5000; t++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule